// File: doc/BRIEF.md
# Hall-Edge Tachometer One-Shot with Position Blanking

This block watches the three Hall-effect position inputs of a brushless motor and, each time the sensed rotor position moves to a new sector, emits a pulse of fixed length on `tach_out`. Because every pulse has the same width, the average level of `tach_out` rises linearly with motor speed. A low-pass filter outside the block turns it into a speed signal.

The same pulse also serves as a blanking window for commutation. The registered position `hall_latched` feeds the commutation decoder. It is frozen for as long as the pulse is high, so switching noise that couples into the sensor lines during chopping cannot produce a false commutation. This also caps the commutation rate. The time between sector changes at the highest intended speed must stay longer than the pulse width, which is set in clock cycles from a clock rate and a width in microseconds (nominally 113 us).

The raw sensor lines are brought into the clock domain through a synchronizer chain. After reset the block primes `hall_latched` with the position that is present, without emitting a pulse. Only one sensor line is expected to change at a time.

Top module: `hall_tach_blank`

## Requirements
- R1: While `rst_n` is low, `tach_out` is 0 and `hall_latched` is 3'b000.
- R2: After reset is released with `hall` held steady, `hall_latched` equals `hall` once SYNC_STAGES+1 rising edges have passed, and no pulse appears on `tach_out` during that priming.
- R3: Once priming is done and no pulse is active, a new held value on `hall` makes `tach_out` rise and `hall_latched` take that value on the same clock edge. That edge is the (SYNC_STAGES+1)-th rising edge, counting the first edge that samples the new value.
- R4: Each pulse on `tach_out` is high for exactly PULSE_CYCLES clock cycles, where PULSE_CYCLES = (CLK_HZ / 1,000,000) * PULSE_US.
- R5: While `tach_out` is high, `hall_latched` does not change. A `hall` change that is undone before the pulse ends has no effect: no later pulse appears and `hall_latched` keeps its value.
- R6: The pulse is not retriggerable. A `hall` change during a pulse does not lengthen that pulse.
- R7: When the pulse ends and the synchronized `hall` differs from `hall_latched`, a new pulse starts after exactly one low cycle, and `hall_latched` takes the new value at that point.
- R8: After priming, `hall_latched` changes only on a clock edge where `tach_out` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| hall | input | 3 | Raw Hall sensor levels, asynchronous to `clk` |
| tach_out | output | 1 | Fixed-width pulse, one per detected position change |
| hall_latched | output | 3 | Blanked rotor position for the commutation decoder |

## Verification
The assertions check on every cycle that the pulse is exactly PULSE_CYCLES long and that the position stays frozen while the pulse is high. They also check that, outside priming, the position moves only together with a rising pulse, and that no pulse appears during priming. Some behaviours need the bench's scenarios: the synchronizer latency from a raw input change to the pulse, the case of a change undone within one blanking window, the single-cycle gap before a pulse for a change that was held through the previous window, and the priming value after reset. The randomized Gray-code walk with varied spacing compares both outputs cycle by cycle against the bench's own model of these rules.

// File: rtl/hall_tach_pkg.sv
package hall_tach_pkg;

  localparam int unsigned HALL_W = 3;

  typedef logic [HALL_W-1:0] hall_vec_t;

  // Pulse length in clock cycles from a clock rate and a width in microseconds.
  function automatic int unsigned pulse_cycles(input int unsigned clk_hz,
                                               input int unsigned width_us);
    int unsigned n;
    n = (clk_hz / 1_000_000) * width_us;
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/hall_sync_chain.sv
module hall_sync_chain #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_async;
      end else begin : g_rest
        assign stage_d = stage_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_d;
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/hall_prime_ctrl.sv
module hall_prime_ctrl #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic primed
);

  localparam int unsigned LIMIT = STAGES + 1;
  localparam int unsigned CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

  logic [CW-1:0] fill_q;
  logic [CW-1:0] fill_d;
  logic          fill_en;

  always_comb begin
    fill_en = (fill_q != LIMIT_V);
    fill_d  = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (fill_en) begin
      fill_q <= fill_d;
    end
  end

  assign primed = (fill_q == LIMIT_V);

endmodule

// File: rtl/hall_pos_reg.sv
module hall_pos_reg
  import hall_tach_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hall_vec_t hall_sync,
  input  logic      primed,
  input  logic      blank,
  output hall_vec_t pos_q,
  output logic      fire
);

  hall_vec_t pos_d;
  logic      pos_en;
  logic      differs;

  always_comb begin
    differs = (hall_sync != pos_q);
    fire    = primed && !blank && differs;
    // During priming the register simply follows the synchronizer.
    pos_en  = !primed || fire;
    pos_d   = hall_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

endmodule

// File: rtl/tach_oneshot.sv
module tach_oneshot #(
  parameter int unsigned PULSE_CYCLES = 5650
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);

  localparam int unsigned CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_V = CW'(PULSE_CYCLES - 1);

  logic          act_q;
  logic          act_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!act_q && fire) begin
      act_d  = 1'b1;
      cnt_d  = LOAD_V;
      cnt_en = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) begin
        act_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active = act_q;

endmodule

// File: rtl/hall_tach_blank.sv
module hall_tach_blank
  import hall_tach_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned PULSE_US    = 113,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall,
  output logic       tach_out,
  output logic [2:0] hall_latched
);

  localparam int unsigned PULSE_CYCLES = pulse_cycles(CLK_HZ, PULSE_US);

  hall_vec_t hall_sync;
  hall_vec_t pos_q;
  logic      primed;
  logic      fire;
  logic      pulse_active;

  hall_sync_chain #(
    .WIDTH  (HALL_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (hall),
    .q_sync  (hall_sync)
  );

  hall_prime_ctrl #(
    .STAGES (SYNC_STAGES)
  ) u_prime (
    .clk    (clk),
    .rst_n  (rst_n),
    .primed (primed)
  );

  hall_pos_reg u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .hall_sync (hall_sync),
    .primed    (primed),
    .blank     (pulse_active),
    .pos_q     (pos_q),
    .fire      (fire)
  );

  tach_oneshot #(
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_shot (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .active (pulse_active)
  );

  assign tach_out     = pulse_active;
  assign hall_latched = pos_q;

endmodule

// File: rtl/hall_tach_blank_chk.sv
module hall_tach_blank_chk #(
  parameter int unsigned PULSE_CYCLES = 5650
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tach_out,
  input logic [2:0] hall_latched,
  input logic       primed
);

  localparam int unsigned HW = $clog2(PULSE_CYCLES + 2);
  localparam logic [HW-1:0] FULL_V = HW'(PULSE_CYCLES);

  logic [HW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
    end else if (tach_out) begin
      if (hi_run != FULL_V) hi_run <= hi_run + 1'b1;
    end else begin
      hi_run <= '0;
    end
  end

  // R4: a high run never outlasts the pulse length
  p_width_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tach_out |-> (hi_run < FULL_V));

  // R4: a pulse that ends was exactly the pulse length
  p_width_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tach_out) |-> (hi_run == FULL_V));

  // R5: position frozen across an edge where the pulse was high
  p_hold_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tach_out) |-> $stable(hall_latched));

  // R8: after priming, position moves only with a rising pulse
  p_move_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && (hall_latched != $past(hall_latched))) |-> $rose(tach_out));

  // R2: no pulse while priming
  p_quiet_prime_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !tach_out);

  // R3: each rising pulse carries a new position
  p_rise_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tach_out) |-> (hall_latched != $past(hall_latched)));

endmodule

bind hall_tach_blank hall_tach_blank_chk #(
  .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tach_out     (tach_out),
  .hall_latched (hall_latched),
  .primed       (primed)
);

// File: tb/hall_tach_blank_test.sv
`timescale 1ns/1ps
module hall_tach_blank_test;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_000_000;
  localparam int PULSE_US   = 24;
  localparam int SYNC       = 2;
  localparam int P          = (CLK_HZ / 1_000_000) * PULSE_US;

  logic       clk;
  logic       rst_n;
  logic [2:0] hall;
  logic       tach_out;
  logic [2:0] hall_latched;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int rises  = 0;
  bit done   = 0;
  bit cmp_en = 0;
  logic prev_tach = 0;

  hall_tach_blank #(
    .CLK_HZ      (CLK_HZ),
    .PULSE_US    (PULSE_US),
    .SYNC_STAGES (SYNC)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hall         (hall),
    .tach_out     (tach_out),
    .hall_latched (hall_latched)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tach_out && !prev_tach) rises++;
    prev_tach = tach_out;
  end

  // Reference model built from the requirements
  logic [2:0] m_s1, m_s2, m_lat;
  int         m_fill, m_rem;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_lat <= 0; m_fill <= 0; m_rem <= 0;
    end else begin
      m_s1 <= hall;
      m_s2 <= m_s1;
      if (m_fill <= SYNC) begin
        m_fill <= m_fill + 1;
        m_lat  <= m_s2;
      end else if (m_rem == 0 && m_s2 != m_lat) begin
        m_lat <= m_s2;
        m_rem <= P;
      end else if (m_rem != 0) begin
        m_rem <= m_rem - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(tach_out == (m_rem != 0), "R8 tach vs model", tach_out, (m_rem != 0));
      chk(hall_latched == m_lat, "R8 position vs model", hall_latched, m_lat);
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_rise(output int at);
    for (int i = 0; i < 10 && !tach_out; i++) step();
    at = cyc;
  endtask

  task automatic wait_fall(output int at);
    for (int i = 0; i < 4*P && tach_out; i++) step();
    at = cyc;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int t_rise, t_fall, r0;
    void'($urandom(32'd4242));
    rst_n = 0;
    hall  = 3'b101;
    repeat (4) step();
    // R1
    chk(tach_out == 0, "R1 tach in reset", tach_out, 0);
    chk(hall_latched == 3'b000, "R1 position in reset", hall_latched, 0);

    rst_n = 1;
    repeat (SYNC + 2) step();
    // R2
    chk(hall_latched == 3'b101, "R2 primed position", hall_latched, 3'b101);
    chk(tach_out == 0, "R2 no pulse after priming", tach_out, 0);
    chk(rises == 0, "R2 no pulse during priming", rises, 0);

    // R3: latency and capture
    hall = 3'b100;
    step();
    chk(tach_out == 0, "R3 not yet (edge 1)", tach_out, 0);
    step();
    chk(tach_out == 0, "R3 not yet (edge 2)", tach_out, 0);
    chk(hall_latched == 3'b101, "R3 old position kept", hall_latched, 3'b101);
    step();
    chk(tach_out == 1, "R3 pulse rises on edge 3", tach_out, 1);
    chk(hall_latched == 3'b100, "R3 new position captured", hall_latched, 3'b100);
    t_rise = cyc;
    // R4
    wait_fall(t_fall);
    chk((t_fall - t_rise) == P, "R4 pulse width", t_fall - t_rise, P);

    // R5: change undone within the pulse
    step();
    hall = 3'b110;
    wait_rise(t_rise);
    chk(hall_latched == 3'b110, "R3 second capture", hall_latched, 3'b110);
    repeat (5) step();
    hall = 3'b010;
    repeat (5) step();
    chk(hall_latched == 3'b110, "R5 position frozen in pulse", hall_latched, 3'b110);
    chk(tach_out == 1, "R5 pulse still high", tach_out, 1);
    hall = 3'b110;
    wait_fall(t_fall);
    chk((t_fall - t_rise) == P, "R6 width unchanged by glitch", t_fall - t_rise, P);
    r0 = rises;
    repeat (10) step();
    chk(rises == r0, "R5 no pulse after undone change", rises, r0);
    chk(hall_latched == 3'b110, "R5 position after undone change", hall_latched, 3'b110);

    // R6 / R7: change held through the pulse
    hall = 3'b111;
    wait_rise(t_rise);
    repeat (4) step();
    hall = 3'b011;
    wait_fall(t_fall);
    chk((t_fall - t_rise) == P, "R6 not retriggered", t_fall - t_rise, P);
    chk(hall_latched == 3'b111, "R7 position before gap", hall_latched, 3'b111);
    step();
    chk(tach_out == 1, "R7 new pulse after one low cycle", tach_out, 1);
    chk(hall_latched == 3'b011, "R7 pending position captured", hall_latched, 3'b011);
    wait_fall(t_fall);
    repeat (3) step();

    // R8: randomized Gray walk against the model
    cmp_en = 1;
    for (int n = 0; n < 250; n++) begin
      int gap;
      if (n < 20) gap = 1 + $urandom_range(0, 3);
      else gap = 1 + $urandom_range(0, 59);
      repeat (gap) step();
      hall = hall ^ (3'b001 << $urandom_range(0, 2));
    end
    repeat (2 * P) step();
    cmp_en = 0;
    finish_run();
  end

endmodule